// File: doc/BRIEF.md
# Encoder Velocity Window Capture

This block measures how fast an encoder turns by counting its count pulses over a fixed, reloadable time window. A down-counting window timer marks the end of each window. At that moment the block latches three things together: the number of pulses seen in the window, the position value presented at its input, and the direction of the last pulse in the window. The next window starts in the same cycle, so windows follow one another with no gap.

One cycle after each capture, the latched speed is compared, unsigned, against a programmable ceiling and a programmable floor. Three sticky event flags record the capture, a speed below the floor and a speed above the ceiling. Each flag is cleared by writing a one to its clear bit, and a per-flag mask bit decides whether the flag can drive the shared interrupt line. Turning quadrature edges into count pulses is done upstream, not here.

Top module: `vel_capture`

## Requirements
- R1: While reset is asserted, `vel_cap`, `pos_cap`, `cap_dir`, `evt_stat` and `irq` are all zero.
- R2: In steady operation a capture occurs every `win_reload`+1 clock cycles. The reload value is sampled when a window starts, so a new value takes effect from the window that begins at the next capture.
- R3: On a capture, `vel_cap` takes the number of cycles in the just-ended window with `cnt_pulse` high, `pos_cap` takes `pos_in` from the capture cycle, and `cap_dir` takes the `cnt_dir` value of the last pulse in the window. A pulse in the capture cycle counts toward the next window.
- R4: The pulse count saturates at 2^VEL_W-1 instead of wrapping.
- R5: `evt_stat[0]` (capture flag) is set in the same edge that loads the capture registers.
- R6: One cycle after a capture, `evt_stat[2]` (over flag) is set if `vel_cap` is strictly greater than `lim_hi`. Equality does not set it.
- R7: One cycle after a capture, `evt_stat[1]` (under flag) is set if `vel_cap` is strictly less than `lim_lo`. Equality does not set it.
- R8: Flags are sticky. A one in `evt_clr[k]` clears `evt_stat[k]` on the next edge and leaves the other flags alone. If a flag is set and cleared on the same edge, the set wins.
- R9: `irq` is high exactly when some flag `k` is set with `evt_mask[k]`=0. A masked flag still sets in `evt_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_pulse | input | 1 | One encoder count in this cycle |
| cnt_dir | input | 1 | Direction of the count in this cycle |
| pos_in | input | POS_W | Current position value |
| win_reload | input | TMR_W | Window length minus one, in cycles |
| lim_hi | input | VEL_W | Speed ceiling |
| lim_lo | input | VEL_W | Speed floor |
| evt_mask | input | 3 | Per-flag interrupt mask, 1 = masked |
| evt_clr | input | 3 | Write-one-to-clear strobes for the flags |
| vel_cap | output | VEL_W | Latched pulse count of the last window |
| pos_cap | output | POS_W | Latched position of the last window |
| cap_dir | output | 1 | Direction of the last pulse of the last window |
| evt_stat | output | 3 | Flags: bit 0 capture, bit 1 under, bit 2 over |
| irq | output | 1 | Interrupt line |

## Verification
On every cycle, the assertions check four things. The window timer steps down by exactly one between captures. A saturated count stays at its maximum. Each capture loads velocity, position and the capture flag on the same edge. Flags hold until they are cleared, an over-limit result raises the over flag, and a fully masked block keeps the interrupt low. The window period and the effect of a late reload change can only be shown by the bench's timed scenarios. The same holds for exact counts under constant, idle and alternating pulse patterns, the equality cases at both limits, and selective clearing and masking.

// File: rtl/vel_capture.sv
module vel_capture #(
  parameter int VEL_W = 16,
  parameter int POS_W = 32,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_pulse,
  input  logic             cnt_dir,
  input  logic [POS_W-1:0] pos_in,
  input  logic [TMR_W-1:0] win_reload,
  input  logic [VEL_W-1:0] lim_hi,
  input  logic [VEL_W-1:0] lim_lo,
  input  logic [2:0]       evt_mask,
  input  logic [2:0]       evt_clr,
  output logic [VEL_W-1:0] vel_cap,
  output logic [POS_W-1:0] pos_cap,
  output logic             cap_dir,
  output logic [2:0]       evt_stat,
  output logic             irq
);

  localparam logic [VEL_W-1:0] VEL_MAX = {VEL_W{1'b1}};

  logic [TMR_W-1:0] tmr;
  logic             tmr_live;
  logic [VEL_W-1:0] vel_cnt;
  logic             last_dir;
  logic             chk_now;
  logic             cap_now;
  logic [2:0]       evt_set;

  assign cap_now = tmr_live && (tmr == '0);
  assign evt_set = {chk_now && (vel_cap > lim_hi),
                    chk_now && (vel_cap < lim_lo),
                    cap_now};
  assign irq = |(evt_stat & ~evt_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr      <= '0;
      tmr_live <= 1'b0;
    end else if (!tmr_live || cap_now) begin
      tmr      <= win_reload;
      tmr_live <= 1'b1;
    end else begin
      tmr <= tmr - TMR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vel_cnt  <= '0;
      last_dir <= 1'b0;
    end else begin
      if (cap_now)
        vel_cnt <= VEL_W'(cnt_pulse);
      else if (cnt_pulse && vel_cnt != VEL_MAX)
        vel_cnt <= vel_cnt + VEL_W'(1);
      if (cnt_pulse)
        last_dir <= cnt_dir;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vel_cap  <= '0;
      pos_cap  <= '0;
      cap_dir  <= 1'b0;
      chk_now  <= 1'b0;
      evt_stat <= '0;
    end else begin
      if (cap_now) begin
        vel_cap <= vel_cnt;
        pos_cap <= pos_in;
        cap_dir <= last_dir;
      end
      chk_now  <= cap_now;
      evt_stat <= (evt_stat & ~evt_clr) | evt_set;
    end
  end

  // R2
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_live && tmr != '0) |=> (tmr == $past(tmr) - TMR_W'(1)));

  // R4
  vel_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vel_cnt == VEL_MAX && cnt_pulse && !cap_now) |=> (vel_cnt == VEL_MAX));

  // R5
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_now |=> (evt_stat[0] && vel_cap == $past(vel_cnt) && pos_cap == $past(pos_in)));

  // R6
  over_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_now && vel_cap > lim_hi) |=> evt_stat[2]);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_stat) |=> ((evt_stat & $past(evt_stat & ~evt_clr)) == $past(evt_stat & ~evt_clr)));

  // R9
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&evt_mask) |-> !irq);

endmodule

// File: tb/vel_capture_test.sv
module vel_capture_test;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 8;
  localparam int PW = 16;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_pulse = 1'b0;
  logic          cnt_dir = 1'b0;
  logic [PW-1:0] pos_in = '0;
  logic [TW-1:0] win_reload = TW'(9);
  logic [VW-1:0] lim_hi = '1;
  logic [VW-1:0] lim_lo = '0;
  logic [2:0]    evt_mask = '0;
  logic [2:0]    evt_clr = '0;
  logic [VW-1:0] vel_cap;
  logic [PW-1:0] pos_cap;
  logic          cap_dir;
  logic [2:0]    evt_stat;
  logic          irq;

  int checks = 0;
  int errors = 0;
  int pmode = 0;
  bit done = 0;

  vel_capture #(.VEL_W(VW), .POS_W(PW), .TMR_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_pulse(cnt_pulse), .cnt_dir(cnt_dir),
    .pos_in(pos_in), .win_reload(win_reload), .lim_hi(lim_hi), .lim_lo(lim_lo),
    .evt_mask(evt_mask), .evt_clr(evt_clr), .vel_cap(vel_cap), .pos_cap(pos_cap),
    .cap_dir(cap_dir), .evt_stat(evt_stat), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (pmode == 0) cnt_pulse = 1'b0;
    else if (pmode == 1) cnt_pulse = 1'b1;
    else cnt_pulse = ~cnt_pulse;
  endtask

  task automatic clear_pulse(input logic [2:0] bits);
    evt_clr = bits;
    tick();
    evt_clr = '0;
  endtask

  task automatic wait_cap();
    for (int i = 0; i < 2000 && !evt_stat[0]; i++) tick();
  endtask

  // returns at the negedge one cycle after a clean capture
  task automatic wait_window();
    clear_pulse(3'b111);
    wait_cap();
    tick();
    clear_pulse(3'b111);
    wait_cap();
    tick();
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1 vel_cap", 32'(vel_cap), 0);
    chk("R1 pos_cap", 32'(pos_cap), 0);
    chk("R1 cap_dir", 32'(cap_dir), 0);
    chk("R1 evt_stat", 32'(evt_stat), 0);
    chk("R1 irq", 32'(irq), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_full_rate();
    pmode = 1; cnt_dir = 1'b1; pos_in = 16'h1234; win_reload = TW'(9);
    lim_hi = '1; lim_lo = '0;
    wait_window();
    chk("R3 count full rate", 32'(vel_cap), 10);
    chk("R3 position latched", 32'(pos_cap), 32'h1234);
    chk("R3 direction latched", 32'(cap_dir), 1);
    chk("R5 capture flag", 32'(evt_stat[0]), 1);
    chk("R6 R7 no limit flags", 32'(evt_stat[2:1]), 0);
    pos_in = 16'h5555;
    tick();
    chk("R3 position held", 32'(pos_cap), 32'h1234);
  endtask

  task automatic t_period();
    int n;
    pmode = 1; win_reload = TW'(9);
    wait_window();
    n = 1;
    clear_pulse(3'b111);
    while (!evt_stat[0] && n < 2000) begin tick(); n++; end
    chk("R2 period", 32'(n), 9);
  endtask

  task automatic t_reload_change();
    pmode = 1; win_reload = TW'(4);
    wait_window();
    chk("R2 new reload", 32'(vel_cap), 5);
    win_reload = TW'(9);
  endtask

  task automatic t_idle_under();
    pmode = 0; lim_lo = VW'(1); lim_hi = '1;
    wait_window();
    chk("R3 idle count", 32'(vel_cap), 0);
    chk("R7 under flag", 32'(evt_stat[1]), 1);
    chk("R6 over clear", 32'(evt_stat[2]), 0);
    lim_lo = '0;
  endtask

  task automatic t_limits();
    pmode = 1; win_reload = TW'(9);
    lim_hi = VW'(9); lim_lo = VW'(10);
    wait_window();
    chk("R6 over above", 32'(evt_stat[2]), 1);
    chk("R7 under equal", 32'(evt_stat[1]), 0);
    lim_hi = VW'(10); lim_lo = VW'(11);
    wait_window();
    chk("R6 over equal", 32'(evt_stat[2]), 0);
    chk("R7 under below", 32'(evt_stat[1]), 1);
    lim_hi = '1; lim_lo = '0;
  endtask

  task automatic t_alt_dir();
    pmode = 2; cnt_dir = 1'b0; win_reload = TW'(9);
    wait_window();
    chk("R3 alternating count", 32'(vel_cap), 5);
    chk("R3 direction zero", 32'(cap_dir), 0);
  endtask

  task automatic t_saturate();
    pmode = 1; win_reload = TW'(300);
    wait_window();
    chk("R4 saturated", 32'(vel_cap), 255);
    win_reload = TW'(9);
    wait_window();
    chk("R4 recovers", 32'(vel_cap), 10);
  endtask

  task automatic t_clear_mask();
    pmode = 0; lim_lo = VW'(1); win_reload = TW'(9);
    wait_window();
    evt_mask = 3'b000;
    #1;
    chk("R9 irq unmasked", 32'(irq), 1);
    evt_mask = 3'b111;
    #1;
    chk("R9 irq all masked", 32'(irq), 0);
    chk("R9 flags still set", 32'(evt_stat[1:0]), 3);
    evt_mask = 3'b010;
    #1;
    chk("R9 capture unmasked", 32'(irq), 1);
    tick(); tick();
    chk("R8 sticky", 32'(evt_stat[1:0]), 3);
    clear_pulse(3'b001);
    chk("R8 selective clear", 32'(evt_stat), 3'b010);
    chk("R9 only masked left", 32'(irq), 0);
    clear_pulse(3'b010);
    chk("R8 clear under", 32'(evt_stat), 0);
    evt_mask = '0; lim_lo = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_full_rate();
    t_period();
    t_reload_change();
    t_idle_under();
    t_limits();
    t_alt_dir();
    t_saturate();
    t_clear_mask();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule